// File: doc/BRIEF.md
# Two-Class Error Collector

The block gathers error events from several sources on every clock. Each event gives an error type index and the address at which the error happened. A parameter mask assigns every error type to either a high-priority or a low-priority class. Type bits are sticky. For each class, the block logs the address of the first error and raises one single-cycle pulse. For the high-priority class it also logs the program counter value present at that first error.

Each class stays frozen after its first error. Later errors of the class still set type bits, but they neither move the logged values nor pulse again. This lasts until software clears every type bit of that class, which re-arms the class. A small write port offers two operations. A force write injects errors by type mask, and its logged address comes from a dedicated force-address input. A clear write removes type bits using write-one-to-clear. A combinational read port returns the type bits and the three logged values.

Top module: `err_collector`

## Requirements
- R1: An event from a source whose type index is t sets type bit t on the next clock edge. Type bits stay set until cleared, and later events only add bits. Read select 0 returns the type bits in the low NUM_TYPES bits.
- R2: The high-priority pulse output goes high for exactly one cycle in the cycle after the first high-priority event, when no high-priority type bit was set.
- R3: While any high-priority type bit is set, further high-priority events produce no pulse but still set their type bits.
- R4: The address of the first high-priority event is logged and readable at read select 1. It stays unchanged while any high-priority type bit is set.
- R5: The pc_i value present with the first high-priority event is logged and readable at read select 3. It follows the same freeze rule. Low-priority events never change it.
- R6: The low-priority class has its own pulse output and its own logged address at read select 2. It follows the same first-error and freeze rules, independently of the high-priority class.
- R7: A write with wr_op_i = 0 (force) sets every type bit given in wr_data_i, as if those errors had occurred, including the class pulses. For a forced type that no source reports in the same cycle, the logged address is force_addr_i.
- R8: A write with wr_op_i = 1 (clear) clears every type bit given by a 1 in wr_data_i. If a set and a clear hit the same bit in one cycle, the bit ends up set.
- R9: A class re-arms once no type bit of that class remains after the clear of the current cycle. A new event in the same cycle as the clear that empties the class is logged and pulses.
- R10: When several types of one armed class arrive in the same cycle, the address (and for high priority, the pc) of the lowest-indexed type is logged.
- R11: When several sources report the same type in one cycle, the address from the lowest-indexed source is used.
- R12: After reset, the type bits and all logged values are zero, and both pulse outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| src_vld_i | input | NUM_SRC | Per-source event valid |
| src_type_i | input | NUM_SRC*TIDX_W | Per-source type index; source s at bits [s*TIDX_W +: TIDX_W] |
| src_addr_i | input | NUM_SRC*ADDR_W | Per-source error address; source s at bits [s*ADDR_W +: ADDR_W] |
| pc_i | input | PC_W | Current program counter value |
| wr_en_i | input | 1 | Register write strobe |
| wr_op_i | input | 1 | 0 = force, 1 = clear |
| wr_data_i | input | NUM_TYPES | Type mask for force or clear |
| force_addr_i | input | ADDR_W | Address logged for forced errors |
| rd_sel_i | input | 2 | 0 types, 1 high address, 2 low address, 3 high pc |
| rd_data_o | output | RD_W | Zero-extended read value |
| hi_pulse_o | output | 1 | High-priority first-error pulse |
| lo_pulse_o | output | 1 | Low-priority first-error pulse |

## Verification
Every result is registered once. The type bits, logged values and pulses therefore reflect a stimulus one clock edge after it is applied. The read port adds no latency. The bench drives inputs 2 ns after a rising edge. For each driven cycle it queues the expected pulse pair, and a monitor compares that pair 1 ns after the following edge. Register values are read back only after a further driven cycle, once the edge that stores them has passed.

// File: rtl/err_pkg.sv
package err_pkg;

    typedef enum logic [1:0] {
        RD_TYPES   = 2'd0,
        RD_HI_ADDR = 2'd1,
        RD_LO_ADDR = 2'd2,
        RD_HI_PC   = 2'd3
    } rd_sel_e;

    typedef enum logic {
        WR_FORCE = 1'b0,
        WR_CLEAR = 1'b1
    } wr_op_e;

    function automatic int unsigned max3(input int unsigned a,
                                         input int unsigned b,
                                         input int unsigned c);
        int unsigned m;
        m = a;
        if (b > m) m = b;
        if (c > m) m = c;
        return m;
    endfunction

endpackage

// File: rtl/err_src_decode.sv
module err_src_decode #(
    parameter int unsigned NUM_TYPES = 16,
    parameter int unsigned NUM_SRC   = 4,
    parameter int unsigned ADDR_W    = 32,
    parameter int unsigned TIDX_W    = 4
) (
    input  logic [NUM_SRC-1:0]          src_vld_i,
    input  logic [NUM_SRC*TIDX_W-1:0]   src_type_i,
    input  logic [NUM_SRC*ADDR_W-1:0]   src_addr_i,
    input  logic [NUM_TYPES-1:0]        force_mask_i,
    input  logic [ADDR_W-1:0]           force_addr_i,
    output logic [NUM_TYPES-1:0]        hit_o,
    output logic [NUM_TYPES*ADDR_W-1:0] type_addr_o
);

    // Per type: a forced hit uses the force address; a source hit overrides it,
    // and the lowest-indexed source is applied last so it wins.
    always_comb begin
        hit_o       = '0;
        type_addr_o = '0;
        for (int t = 0; t < int'(NUM_TYPES); t++) begin
            hit_o[t]                        = force_mask_i[t];
            type_addr_o[t*ADDR_W +: ADDR_W] = force_addr_i;
            for (int s = int'(NUM_SRC) - 1; s >= 0; s--) begin
                if (src_vld_i[s] &&
                    (src_type_i[s*TIDX_W +: TIDX_W] == TIDX_W'(t))) begin
                    hit_o[t]                        = 1'b1;
                    type_addr_o[t*ADDR_W +: ADDR_W] = src_addr_i[s*ADDR_W +: ADDR_W];
                end
            end
        end
    end

endmodule

// File: rtl/err_class_log.sv
module err_class_log #(
    parameter int unsigned          NUM_TYPES  = 16,
    parameter int unsigned          ADDR_W     = 32,
    parameter int unsigned          PC_W       = 32,
    parameter logic [NUM_TYPES-1:0] CLASS_MASK = '1,
    parameter bit                   KEEP_PC    = 1'b1
) (
    input  logic                        clk_i,
    input  logic                        rst_ni,
    input  logic [NUM_TYPES-1:0]        hit_i,
    input  logic [NUM_TYPES-1:0]        types_q_i,
    input  logic [NUM_TYPES-1:0]        clr_i,
    input  logic [NUM_TYPES*ADDR_W-1:0] type_addr_i,
    input  logic [PC_W-1:0]             pc_i,
    output logic                        pulse_o,
    output logic [ADDR_W-1:0]           addr_o,
    output logic [PC_W-1:0]             pc_o
);

    typedef struct packed {
        logic              pulse;
        logic [ADDR_W-1:0] addr;
        logic [PC_W-1:0]   pc;
    } log_t;

    log_t log_d, log_q;

    logic [NUM_TYPES-1:0] remain;
    logic [NUM_TYPES-1:0] new_hits;
    logic                 armed;
    logic                 trig;
    int                   sel;

    always_comb begin
        remain   = types_q_i & ~clr_i & CLASS_MASK;
        new_hits = hit_i & CLASS_MASK;
        armed    = ~|remain;
        trig     = armed && (|new_hits);
        sel      = 0;
        for (int i = int'(NUM_TYPES) - 1; i >= 0; i--) begin
            if (new_hits[i]) sel = i;
        end
        log_d       = log_q;
        log_d.pulse = trig;
        if (trig) begin
            log_d.addr = type_addr_i[sel*ADDR_W +: ADDR_W];
            log_d.pc   = KEEP_PC ? pc_i : '0;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) log_q <= '0;
        else         log_q <= log_d;
    end

    assign pulse_o = log_q.pulse;
    assign addr_o  = log_q.addr;
    assign pc_o    = log_q.pc;

endmodule

// File: rtl/err_read_mux.sv
module err_read_mux #(
    parameter int unsigned NUM_TYPES = 16,
    parameter int unsigned ADDR_W    = 32,
    parameter int unsigned PC_W      = 32,
    parameter int unsigned RD_W      = 32
) (
    input  logic [1:0]           rd_sel_i,
    input  logic [NUM_TYPES-1:0] types_i,
    input  logic [ADDR_W-1:0]    hi_addr_i,
    input  logic [ADDR_W-1:0]    lo_addr_i,
    input  logic [PC_W-1:0]      hi_pc_i,
    output logic [RD_W-1:0]      rd_data_o
);
    import err_pkg::*;

    always_comb begin
        unique case (rd_sel_e'(rd_sel_i))
            RD_TYPES:   rd_data_o = RD_W'(types_i);
            RD_HI_ADDR: rd_data_o = RD_W'(hi_addr_i);
            RD_LO_ADDR: rd_data_o = RD_W'(lo_addr_i);
            RD_HI_PC:   rd_data_o = RD_W'(hi_pc_i);
            default:    rd_data_o = '0;
        endcase
    end

endmodule

// File: rtl/err_collector.sv
module err_collector #(
    parameter int unsigned            NUM_TYPES = 16,
    parameter int unsigned            NUM_SRC   = 4,
    parameter int unsigned            ADDR_W    = 32,
    parameter int unsigned            PC_W      = 32,
    parameter logic [NUM_TYPES-1:0]   HI_MASK   = 16'h00FF,
    localparam int unsigned           TIDX_W    = (NUM_TYPES > 1) ? $clog2(NUM_TYPES) : 1,
    localparam int unsigned           RD_W      = err_pkg::max3(NUM_TYPES, ADDR_W, PC_W)
) (
    input  logic                      clk_i,
    input  logic                      rst_ni,
    input  logic [NUM_SRC-1:0]        src_vld_i,
    input  logic [NUM_SRC*TIDX_W-1:0] src_type_i,
    input  logic [NUM_SRC*ADDR_W-1:0] src_addr_i,
    input  logic [PC_W-1:0]           pc_i,
    input  logic                      wr_en_i,
    input  logic                      wr_op_i,
    input  logic [NUM_TYPES-1:0]      wr_data_i,
    input  logic [ADDR_W-1:0]         force_addr_i,
    input  logic [1:0]                rd_sel_i,
    output logic [RD_W-1:0]           rd_data_o,
    output logic                      hi_pulse_o,
    output logic                      lo_pulse_o
);
    import err_pkg::*;

    localparam int unsigned NUM_CLS = 2;

    typedef struct packed {
        logic [NUM_TYPES-1:0] types;
    } state_t;

    state_t st_d, st_q;

    logic [NUM_TYPES-1:0]        force_mask;
    logic [NUM_TYPES-1:0]        clr_mask;
    logic [NUM_TYPES-1:0]        hit;
    logic [NUM_TYPES*ADDR_W-1:0] type_addr;
    logic [NUM_TYPES-1:0]        types_q;
    logic [NUM_CLS-1:0]          cls_pulse;
    logic [ADDR_W-1:0]           cls_addr [NUM_CLS];
    logic [PC_W-1:0]             cls_pc   [NUM_CLS];
    logic [ADDR_W-1:0]           hi_addr, lo_addr;
    logic [PC_W-1:0]             hi_pc;

    assign force_mask = (wr_en_i && (wr_op_e'(wr_op_i) == WR_FORCE)) ? wr_data_i : '0;
    assign clr_mask   = (wr_en_i && (wr_op_e'(wr_op_i) == WR_CLEAR)) ? wr_data_i : '0;

    err_src_decode #(
        .NUM_TYPES (NUM_TYPES),
        .NUM_SRC   (NUM_SRC),
        .ADDR_W    (ADDR_W),
        .TIDX_W    (TIDX_W)
    ) u_decode (
        .src_vld_i    (src_vld_i),
        .src_type_i   (src_type_i),
        .src_addr_i   (src_addr_i),
        .force_mask_i (force_mask),
        .force_addr_i (force_addr_i),
        .hit_o        (hit),
        .type_addr_o  (type_addr)
    );

    // Set wins over clear on the same bit.
    always_comb begin
        st_d       = st_q;
        st_d.types = (st_q.types & ~clr_mask) | hit;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign types_q = st_q.types;

    for (genvar c = 0; c < int'(NUM_CLS); c++) begin : g_cls
        localparam logic [NUM_TYPES-1:0] CMASK = (c == 0) ? HI_MASK : ~HI_MASK;
        err_class_log #(
            .NUM_TYPES  (NUM_TYPES),
            .ADDR_W     (ADDR_W),
            .PC_W       (PC_W),
            .CLASS_MASK (CMASK),
            .KEEP_PC    (c == 0)
        ) u_log (
            .clk_i       (clk_i),
            .rst_ni      (rst_ni),
            .hit_i       (hit),
            .types_q_i   (types_q),
            .clr_i       (clr_mask),
            .type_addr_i (type_addr),
            .pc_i        (pc_i),
            .pulse_o     (cls_pulse[c]),
            .addr_o      (cls_addr[c]),
            .pc_o        (cls_pc[c])
        );
    end

    assign hi_addr    = cls_addr[0];
    assign lo_addr    = cls_addr[1];
    assign hi_pc      = cls_pc[0];
    assign hi_pulse_o = cls_pulse[0];
    assign lo_pulse_o = cls_pulse[1];

    err_read_mux #(
        .NUM_TYPES (NUM_TYPES),
        .ADDR_W    (ADDR_W),
        .PC_W      (PC_W),
        .RD_W      (RD_W)
    ) u_rd (
        .rd_sel_i  (rd_sel_i),
        .types_i   (types_q),
        .hi_addr_i (hi_addr),
        .lo_addr_i (lo_addr),
        .hi_pc_i   (hi_pc),
        .rd_data_o (rd_data_o)
    );

endmodule

// File: rtl/err_collector_chk.sv
module err_collector_chk #(
    parameter int unsigned          NUM_TYPES = 16,
    parameter int unsigned          ADDR_W    = 32,
    parameter int unsigned          PC_W      = 32,
    parameter logic [NUM_TYPES-1:0] HI_MASK   = 16'h00FF
) (
    input logic                 clk_i,
    input logic                 rst_ni,
    input logic [NUM_TYPES-1:0] types_q,
    input logic                 hi_pulse,
    input logic                 lo_pulse,
    input logic [ADDR_W-1:0]    hi_addr,
    input logic [ADDR_W-1:0]    lo_addr,
    input logic [PC_W-1:0]      hi_pc,
    input logic                 wr_en,
    input logic                 wr_op,
    input logic [NUM_TYPES-1:0] wr_data
);
    logic clr_wr, frc_wr, hi_busy, lo_busy;
    assign clr_wr  = wr_en && wr_op;
    assign frc_wr  = wr_en && !wr_op;
    assign hi_busy = |(types_q & HI_MASK);
    assign lo_busy = |(types_q & ~HI_MASK);

    p_sticky_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !clr_wr |=> ((types_q & $past(types_q)) == $past(types_q)));

    p_hi_cause_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        hi_pulse |-> hi_busy);

    p_hi_width_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (hi_pulse && !clr_wr) |=> !hi_pulse);

    p_hi_freeze_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (hi_busy && !clr_wr) |=> ($stable(hi_addr) && !hi_pulse));

    p_pc_freeze_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (hi_busy && !clr_wr) |=> $stable(hi_pc));

    p_lo_freeze_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (lo_busy && !clr_wr) |=> ($stable(lo_addr) && !lo_pulse));

    p_lo_cause_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        lo_pulse |-> lo_busy);

    p_force_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        frc_wr |=> ((types_q & $past(wr_data)) == $past(wr_data)));

endmodule

bind err_collector err_collector_chk #(
    .NUM_TYPES (NUM_TYPES),
    .ADDR_W    (ADDR_W),
    .PC_W      (PC_W),
    .HI_MASK   (HI_MASK)
) u_chk (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .types_q  (types_q),
    .hi_pulse (hi_pulse_o),
    .lo_pulse (lo_pulse_o),
    .hi_addr  (hi_addr),
    .lo_addr  (lo_addr),
    .hi_pc    (hi_pc),
    .wr_en    (wr_en_i),
    .wr_op    (wr_op_i),
    .wr_data  (wr_data_i)
);

// File: tb/test_err_collector.sv
module test_err_collector;

    localparam int NT = 16;
    localparam int NS = 4;
    localparam int AW = 32;
    localparam int TW = 4;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [NS-1:0]   src_vld = '0;
    logic [NS*TW-1:0] src_type = '0;
    logic [NS*AW-1:0] src_addr = '0;
    logic [31:0]     pc = '0;
    logic            wr_en = 1'b0;
    logic            wr_op = 1'b0;
    logic [NT-1:0]   wr_data = '0;
    logic [AW-1:0]   faddr = '0;
    logic [1:0]      rd_sel = '0;
    logic [31:0]     rd_data;
    logic            hi_pulse, lo_pulse;

    // staging for the next driven cycle
    logic [NS-1:0]    s_vld = '0;
    logic [NS*TW-1:0] s_type = '0;
    logic [NS*AW-1:0] s_addr = '0;
    logic [31:0]      s_pc = '0;
    logic             s_wr_en = 1'b0;
    logic             s_wr_op = 1'b0;
    logic [NT-1:0]    s_wr_data = '0;
    logic [AW-1:0]    s_faddr = '0;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    typedef struct {
        logic  hi;
        logic  lo;
        string req;
    } exp_t;
    exp_t exp_q[$];

    always #10 clk = ~clk;

    err_collector i_err_collector (
        .clk_i        (clk),
        .rst_ni       (rst_n),
        .src_vld_i    (src_vld),
        .src_type_i   (src_type),
        .src_addr_i   (src_addr),
        .pc_i         (pc),
        .wr_en_i      (wr_en),
        .wr_op_i      (wr_op),
        .wr_data_i    (wr_data),
        .force_addr_i (faddr),
        .rd_sel_i     (rd_sel),
        .rd_data_o    (rd_data),
        .hi_pulse_o   (hi_pulse),
        .lo_pulse_o   (lo_pulse)
    );

    task automatic ev(input int s, input int t, input logic [31:0] a);
        s_vld[s]         = 1'b1;
        s_type[s*TW +: TW] = TW'(t);
        s_addr[s*AW +: AW] = a;
    endtask

    task automatic wr(input logic op, input logic [NT-1:0] d, input logic [31:0] fa);
        s_wr_en   = 1'b1;
        s_wr_op   = op;
        s_wr_data = d;
        s_faddr   = fa;
    endtask

    // drive one cycle, queue the pulses expected one edge later
    task automatic step(input logic eh, input logic el, input string req);
        exp_t e;
        @(posedge clk);
        #2;
        src_vld  = s_vld;  src_type = s_type; src_addr = s_addr; pc = s_pc;
        wr_en    = s_wr_en; wr_op = s_wr_op; wr_data = s_wr_data; faddr = s_faddr;
        e.hi = eh; e.lo = el; e.req = req;
        exp_q.push_back(e);
        s_vld = '0; s_wr_en = 1'b0; s_wr_data = '0;
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic rd(input int sel, input logic [31:0] exp, input string req);
        rd_sel = 2'(sel);
        #1;
        chk(req, rd_data, exp);
    endtask

    // monitor: compare pulses one edge after each driven cycle
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (exp_q.size() > 0) begin
                exp_t e;
                e = exp_q.pop_front();
                chk({e.req, " hi_pulse"}, {31'd0, hi_pulse}, {31'd0, e.hi});
                chk({e.req, " lo_pulse"}, {31'd0, lo_pulse}, {31'd0, e.lo});
            end
        end
    end

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        #2;
        // R12: reset state
        rd(0, 32'h0, "R12 types");
        rd(1, 32'h0, "R12 hi addr");
        rd(2, 32'h0, "R12 lo addr");
        rd(3, 32'h0, "R12 hi pc");
        chk("R12 pulses", {30'd0, hi_pulse, lo_pulse}, 32'h0);
        rst_n = 1'b1;
        step(0, 0, "R12 idle");

        // R1 R2 R4 R5: first high-priority error
        s_pc = 32'h0000_1100;
        ev(1, 3, 32'hA000_0001);
        step(1, 0, "R2 first hi");
        step(0, 0, "R2 one cycle");
        rd(0, 32'h0000_0008, "R1 type bit 3");
        rd(1, 32'hA000_0001, "R4 hi addr");
        rd(3, 32'h0000_1100, "R5 hi pc");
        rd(2, 32'h0, "R6 lo untouched");

        // R3: later hi error accumulates only
        s_pc = 32'h0000_2200;
        ev(0, 5, 32'hA000_0002);
        step(0, 0, "R3 no second pulse");
        step(0, 0, "R3 idle");
        rd(0, 32'h0000_0028, "R3 accumulate");
        rd(1, 32'hA000_0001, "R4 frozen addr");
        rd(3, 32'h0000_1100, "R5 frozen pc");

        // R6: low class independent
        s_pc = 32'h0000_3300;
        ev(2, 9, 32'hB000_0003);
        step(0, 1, "R6 first lo");
        ev(3, 12, 32'hB000_0004);
        step(0, 0, "R6 no second lo");
        step(0, 0, "R6 idle");
        rd(2, 32'hB000_0003, "R6 lo addr");
        rd(3, 32'h0000_1100, "R5 pc not from lo");
        rd(0, 32'h0000_1228, "R6 types");

        // R9: partial clear does not re-arm
        wr(1'b1, 16'h0008, 32'h0);
        step(0, 0, "R8 partial clear");
        ev(0, 1, 32'hA000_0005);
        step(0, 0, "R9 not rearmed");
        step(0, 0, "R9 idle");
        rd(0, 32'h0000_1222, "R8 bit3 cleared");
        rd(1, 32'hA000_0001, "R9 addr kept");

        // R9: clear emptying class plus new error same cycle
        s_pc = 32'h0000_4400;
        wr(1'b1, 16'h00FF, 32'h0);
        ev(0, 7, 32'hA000_0006);
        step(1, 0, "R9 rearm same cycle");
        step(0, 0, "R9 idle");
        rd(0, 32'h0000_1280, "R9 types");
        rd(1, 32'hA000_0006, "R9 new addr");
        rd(3, 32'h0000_4400, "R9 new pc");

        // R8: set wins over clear on same bit
        wr(1'b1, 16'h1000, 32'h0);
        ev(3, 12, 32'hB000_0007);
        step(0, 0, "R8 set wins");
        step(0, 0, "R8 idle");
        rd(0, 32'h0000_1280, "R8 bit12 kept");
        rd(2, 32'hB000_0003, "R6 lo addr frozen");

        // R8: full clear
        wr(1'b1, 16'hFFFF, 32'h0);
        step(0, 0, "R8 clear all");
        step(0, 0, "R8 idle");
        rd(0, 32'h0, "R8 all cleared");

        // R10: lowest type index wins
        s_pc = 32'h0000_5500;
        ev(0, 6, 32'hC000_0000);
        ev(1, 2, 32'hC000_0001);
        ev(2, 14, 32'hC000_0002);
        ev(3, 10, 32'hC000_0003);
        step(1, 1, "R10 both classes");
        step(0, 0, "R10 idle");
        rd(1, 32'hC000_0001, "R10 hi lowest type");
        rd(2, 32'hC000_0003, "R10 lo lowest type");
        rd(3, 32'h0000_5500, "R10 hi pc");
        rd(0, 32'h0000_4444, "R1 multi types");
        wr(1'b1, 16'hFFFF, 32'h0);
        step(0, 0, "R8 clear");

        // R11: lowest source wins for one type
        ev(2, 4, 32'hD000_0002);
        ev(1, 4, 32'hD000_0001);
        step(1, 0, "R11 pulse");
        step(0, 0, "R11 idle");
        rd(1, 32'hD000_0001, "R11 lowest source");
        wr(1'b1, 16'hFFFF, 32'h0);
        step(0, 0, "R8 clear");

        // R7: force write
        s_pc = 32'h0000_6600;
        wr(1'b0, 16'h0801, 32'hF000_0001);
        step(1, 1, "R7 force pulses");
        step(0, 0, "R7 idle");
        rd(0, 32'h0000_0801, "R7 forced bits");
        rd(1, 32'hF000_0001, "R7 hi force addr");
        rd(2, 32'hF000_0001, "R7 lo force addr");
        rd(3, 32'h0000_6600, "R7 hi pc");

        step(0, 0, "drain");
        step(0, 0, "drain");
        repeat (2) @(posedge clk);
        #5;
        finish_run();
    end

endmodule